// File: doc/BRIEF.md
# Operand dependency interlock

This block sits in the issue stage of an in-order core and decides whether the instruction now waiting to issue must be held back, because a register it reads is still being produced by an earlier instruction. The block keeps one entry per architectural register. Each entry holds whether a producer is pending, the class of the instruction that last wrote the register, and a saturating count of the cycles since that instruction issued.

For each source operand, the block picks a minimum issue separation from the producer class, the consumer class and a per-operand flag. The flag tells the block whether the consumer needs the value early, for example as a shift input, a multiplier operand or a store address. Results that are not needed early reach the consumer through forwarding paths, so the separation is shorter. The stall output is combinational. An instruction issues on a rising clock edge when `iss_valid` is high and `stall` is low. If it writes a register, it then replaces that register's entry.

Top module: `dep_interlock`

Class codes used on `iss_class`:

| Code | Class |
|------|-------|
| 0 | plain or constant-shift ALU |
| 1 | register-shift ALU |
| 2 | 32-bit multiply |
| 3 | 64-bit multiply |
| 4 | 16x16 multiply |
| 5 | 16x16-into-64 or top-word multiply |
| 6 | word or double load |
| 7 | byte load |
| 8 | three or four register load |
| 9 | store |
| 10 | branch |

Codes 11 to 15 write nothing, and as consumers they use the default latency.

Separation s means the consumer may issue s cycles after the producer issued. A consumer presented in the cycle right after its producer therefore stalls for s-1 cycles.

## Requirements
- R1: After synchronous reset, and after any later reset, no register has a pending producer, and `stall` is 0 for any sources.
- R2: `stall` is 1 only when `iss_valid` is 1 and at least one source whose `src_used` bit is 1 is not yet ready. The most-delayed used source governs the stall, and sources with `src_used` at 0 are ignored.
- R3: Default separations apply when the consumer marks the operand early (`src_early`=1), and whenever the consumer is a load (codes 6-8). They are: ALU 2, register-shift ALU 3, 32-bit multiply 4, 64-bit multiply 5, 16x16 multiply 3, code 5 multiply 4, word load 3, byte load 4, multi-register load 4.
- R4: For a non-early operand of an ALU, multiply or store consumer (codes 0-5, 9), an ALU producer (code 0) needs separation 1 and a register-shift ALU producer (code 1) needs 2.
- R5: For the same non-early consumers, multiply producers need: code 2 needs 3, code 3 needs 4, code 4 needs 2, and code 5 needs 3.
- R6: For the same non-early consumers, a word load needs 2 and a byte load needs 3. A multi-register load needs 3 before a multiply consumer and 4 before an ALU or store consumer.
- R7: A branch consumer (code 10) ignores `src_early`. It needs 1 after code 0, 2 after code 1 or code 6, 3 after code 8, and the default separation after any other producer.
- R8: A store or branch that issues, or any issuing instruction with `iss_dst_wr`=0, leaves the destination entry unchanged.
- R9: An issuing instruction that writes a result replaces its destination entry, so later consumers time against the newest producer only.
- R10: While `stall` is 1, nothing issues and the table is not written. A source that is ready stays ready until a new write, so a stall lasts at most 4 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 4 | Class code of the presented instruction |
| iss_dst | input | 4 | Destination register number |
| iss_dst_wr | input | 1 | The instruction writes `iss_dst` |
| src_reg | input | 2x4 | Source register numbers, packed per source |
| src_used | input | 2 | Per-source: the operand is read |
| src_early | input | 2 | Per-source: the operand is needed early |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
The main function is driven by a vector table of producer/consumer pairs, each presented one cycle after its producer. The table covers every producer class against ALU, multiply, store, branch and load consumers, with the early flag both set and clear. This separates the forwarding column from the default column, and it shows that branch consumers ignore the flag. Directed sequences then cover the remaining cases. Two back-to-back writers to one register show that only the newest producer counts. A store, or a write with its write bit clear, following a long multiply shows that nothing was overwritten. Two sources with different readiness show that the slower one governs. A consumer that arrives late shows that the age counts cycles rather than events.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int CLS_W   = 4;
    localparam int MAX_SEP = 5;

    typedef enum logic [CLS_W-1:0] {
        OP_ALU    = 4'd0,
        OP_ALU_RS = 4'd1,
        OP_MUL_W  = 4'd2,
        OP_MUL_L  = 4'd3,
        OP_MUL_H  = 4'd4,
        OP_MUL_HL = 4'd5,
        OP_LD_W   = 4'd6,
        OP_LD_B   = 4'd7,
        OP_LD_M   = 4'd8,
        OP_ST     = 4'd9,
        OP_BR     = 4'd10
    } op_cls_e;

    typedef struct packed {
        logic    live;
        op_cls_e cls;
    } prod_t;

    function automatic logic is_mul(op_cls_e c);
        return (c == OP_MUL_W) || (c == OP_MUL_L) ||
               (c == OP_MUL_H) || (c == OP_MUL_HL);
    endfunction

    function automatic logic writes_result(op_cls_e c);
        return (c <= OP_LD_M);
    endfunction

    // consumers that can take a forwarded value when not needed early
    function automatic logic fwd_consumer(op_cls_e c);
        return (c == OP_ALU) || (c == OP_ALU_RS) || is_mul(c) || (c == OP_ST);
    endfunction

    function automatic logic [2:0] base_lat(op_cls_e p);
        case (p)
            OP_ALU:    return 3'd2;
            OP_ALU_RS: return 3'd3;
            OP_MUL_W:  return 3'd4;
            OP_MUL_L:  return 3'd5;
            OP_MUL_H:  return 3'd3;
            OP_MUL_HL: return 3'd4;
            OP_LD_W:   return 3'd3;
            OP_LD_B:   return 3'd4;
            OP_LD_M:   return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] fwd_lat(op_cls_e p, op_cls_e c);
        case (p)
            OP_ALU:    return 3'd1;
            OP_ALU_RS: return 3'd2;
            OP_MUL_W:  return 3'd3;
            OP_MUL_L:  return 3'd4;
            OP_MUL_H:  return 3'd2;
            OP_MUL_HL: return 3'd3;
            OP_LD_W:   return 3'd2;
            OP_LD_B:   return 3'd3;
            OP_LD_M:   return is_mul(c) ? 3'd3 : 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] br_lat(op_cls_e p);
        case (p)
            OP_ALU:    return 3'd1;
            OP_ALU_RS: return 3'd2;
            OP_LD_W:   return 3'd2;
            OP_LD_M:   return 3'd3;
            default:   return base_lat(p);
        endcase
    endfunction

    function automatic logic [2:0] sep_need(op_cls_e p, op_cls_e c, logic early);
        if (c == OP_BR)
            return br_lat(p);
        if (!early && fwd_consumer(c))
            return fwd_lat(p, c);
        return base_lat(p);
    endfunction

endpackage

// File: rtl/ilk_entry_tbl.sv
module ilk_entry_tbl
    import ilk_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int CNT_W = 3,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  op_cls_e          wr_cls,
    output prod_t            prod_o [NREG],
    output logic [CNT_W-1:0] age_o  [NREG]
);

    localparam logic [CNT_W-1:0] AGE_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] AGE_ONE = CNT_W'(1);

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        prod_t            prod_q;
        logic [CNT_W-1:0] age_q;

        // age is loaded with one: the cycle after issue is one cycle of separation
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q <= '{live: 1'b0, cls: OP_ALU};
                age_q  <= AGE_MAX;
            end else if (wr_en && (wr_idx == REG_W'(i))) begin
                prod_q <= '{live: 1'b1, cls: wr_cls};
                age_q  <= AGE_ONE;
            end else if (age_q != AGE_MAX) begin
                age_q  <= age_q + AGE_ONE;
            end
        end

        assign prod_o[i] = prod_q;
        assign age_o[i]  = age_q;
    end

endmodule

// File: rtl/ilk_src_chk.sv
module ilk_src_chk
    import ilk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  prod_t            prod,
    input  logic [CNT_W-1:0] age,
    input  op_cls_e          cons_cls,
    input  logic             used,
    input  logic             early,
    output logic             wait_o
);

    logic [2:0] sep;

    always_comb begin
        sep    = sep_need(prod.cls, cons_cls, early);
        wait_o = used && prod.live && (int'(age) < int'(sep));
    end

    // R3
    sep_range_chk: assert property (@(posedge clk) disable iff (rst)
        prod.live |-> (sep >= 3'd1 && int'(sep) <= MAX_SEP));

endmodule

// File: rtl/dep_interlock.sv
module dep_interlock
    import ilk_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int CNT_W = 3,
    parameter int NSRC  = 2,
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    input  logic [CLS_W-1:0]           iss_class,
    input  logic [REG_W-1:0]           iss_dst,
    input  logic                       iss_dst_wr,
    input  logic [NSRC-1:0][REG_W-1:0] src_reg,
    input  logic [NSRC-1:0]            src_used,
    input  logic [NSRC-1:0]            src_early,
    output logic                       stall
);

    op_cls_e          cls;
    prod_t            prod_tab [NREG];
    logic [CNT_W-1:0] age_tab  [NREG];
    logic [NSRC-1:0]  wait_v;
    logic             wr_en;

    assign cls   = op_cls_e'(iss_class);
    assign stall = iss_valid && (|wait_v);
    assign wr_en = iss_valid && !stall && iss_dst_wr && writes_result(cls);

    ilk_entry_tbl #(.NREG(NREG), .CNT_W(CNT_W)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (iss_dst),
        .wr_cls (cls),
        .prod_o (prod_tab),
        .age_o  (age_tab)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        ilk_src_chk #(.CNT_W(CNT_W)) u_chk (
            .clk      (clk),
            .rst      (rst),
            .prod     (prod_tab[src_reg[s]]),
            .age      (age_tab[src_reg[s]]),
            .cons_cls (cls),
            .used     (src_used[s]),
            .early    (src_early[s]),
            .wait_o   (wait_v[s])
        );

        // R10
        ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(!wait_v[s] && !wr_en) && $stable(src_reg[s]) &&
             $stable(iss_class) && $stable(src_used[s]) && $stable(src_early[s]))
            |-> !wait_v[s]);
    end

    logic [2:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst)
            stall_run <= '0;
        else if (stall && stall_run != 3'd7)
            stall_run <= stall_run + 3'd1;
        else if (!stall)
            stall_run <= '0;
    end

    // R10
    stall_run_chk: assert property (@(posedge clk) disable iff (rst)
        int'(stall_run) <= MAX_SEP - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall);

endmodule

// File: tb/dep_interlock_bench.sv
module dep_interlock_bench;
    import ilk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            iss_valid = 1'b0;
    logic [3:0]      iss_class = '0;
    logic [3:0]      iss_dst = '0;
    logic            iss_dst_wr = 1'b0;
    logic [1:0][3:0] src_reg = '0;
    logic [1:0]      src_used = '0;
    logic [1:0]      src_early = '0;
    logic            stall;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dep_interlock u_dep_interlock (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst(iss_dst), .iss_dst_wr(iss_dst_wr), .src_reg(src_reg),
        .src_used(src_used), .src_early(src_early), .stall(stall)
    );

    // {producer, consumer, early, separation}
    localparam logic [12:0] VEC [NV] = '{
        {OP_ALU,    OP_ALU,    1'b0, 4'd1},  // R4
        {OP_ALU,    OP_ALU,    1'b1, 4'd2},  // R3
        {OP_ALU_RS, OP_ALU,    1'b0, 4'd2},  // R4
        {OP_ALU_RS, OP_ALU_RS, 1'b1, 4'd3},  // R3
        {OP_MUL_W,  OP_ALU,    1'b0, 4'd3},  // R5
        {OP_MUL_W,  OP_MUL_W,  1'b1, 4'd4},  // R3
        {OP_MUL_L,  OP_MUL_H,  1'b0, 4'd4},  // R5
        {OP_MUL_L,  OP_ALU,    1'b1, 4'd5},  // R3
        {OP_MUL_H,  OP_ST,     1'b0, 4'd2},  // R5
        {OP_MUL_H,  OP_ALU,    1'b1, 4'd3},  // R3
        {OP_MUL_HL, OP_ALU,    1'b0, 4'd3},  // R5
        {OP_MUL_HL, OP_ALU,    1'b1, 4'd4},  // R3
        {OP_LD_W,   OP_ALU,    1'b0, 4'd2},  // R6
        {OP_LD_W,   OP_ST,     1'b1, 4'd3},  // R3
        {OP_LD_W,   OP_BR,     1'b1, 4'd2},  // R7
        {OP_LD_B,   OP_ALU,    1'b0, 4'd3},  // R6
        {OP_LD_B,   OP_BR,     1'b0, 4'd4},  // R7
        {OP_LD_M,   OP_MUL_W,  1'b0, 4'd3},  // R6
        {OP_LD_M,   OP_ALU,    1'b0, 4'd4},  // R6
        {OP_LD_M,   OP_BR,     1'b0, 4'd3},  // R7
        {OP_ALU,    OP_BR,     1'b1, 4'd1},  // R7
        {OP_ALU_RS, OP_BR,     1'b0, 4'd2},  // R7
        {OP_ALU,    OP_LD_W,   1'b0, 4'd2},  // R3
        {OP_MUL_W,  OP_BR,     1'b0, 4'd4},  // R7
        {OP_ALU,    OP_ST,     1'b0, 4'd1}   // R4
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        iss_valid = 1'b0; iss_dst_wr = 1'b0; src_used = '0; src_early = '0;
    endtask

    task automatic produce(logic [3:0] c, logic [3:0] d, logic wr);
        @(negedge clk);
        iss_valid = 1'b1; iss_class = c; iss_dst = d; iss_dst_wr = wr;
        src_used = '0; src_early = '0;
    endtask

    task automatic consume(logic [3:0] c, logic [3:0] r0, logic u0, logic e0,
                           logic [3:0] r1, logic u1, logic e1);
        @(negedge clk);
        iss_valid = 1'b1; iss_class = c; iss_dst_wr = 1'b0;
        src_reg[0] = r0; src_used[0] = u0; src_early[0] = e0;
        src_reg[1] = r1; src_used[1] = u1; src_early[1] = e1;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        #1;
        while (stall && n < 20) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty table after reset
        consume(OP_ALU, 4'd3, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1);
        count_stall(n);
        chk("R1 reset state", n, 0);
        go_idle();

        // main table: consumer presented right after its producer
        for (int k = 0; k < NV; k++) begin
            logic [3:0] r;
            r = 4'(k % 16);
            produce(VEC[k][12:9], r, 1'b1);
            consume(VEC[k][8:5], r, 1'b1, VEC[k][4], 4'd0, 1'b0, 1'b0);
            count_stall(n);
            chk($sformatf("R3-R7 vector %0d", k), n, int'(VEC[k][3:0]) - 1);
            go_idle();
            repeat (6) @(negedge clk);
        end

        // R2: no stall without a valid instruction, unused source ignored
        produce(OP_MUL_L, 4'd2, 1'b1);
        @(negedge clk);
        iss_valid = 1'b0; src_reg[0] = 4'd2; src_used[0] = 1'b1; src_early[0] = 1'b1;
        #1 chk("R2 no valid no stall", int'(stall), 0);
        consume(OP_ALU, 4'd2, 1'b0, 1'b1, 4'd9, 1'b1, 1'b1);
        #1 chk("R2 unused source ignored", int'(stall), 0);
        go_idle();
        repeat (6) @(negedge clk);

        // R2: slower of two sources governs
        produce(OP_LD_B, 4'd7, 1'b1);
        produce(OP_ALU, 4'd8, 1'b1);
        consume(OP_ALU, 4'd8, 1'b1, 1'b0, 4'd7, 1'b1, 1'b0);
        count_stall(n);
        chk("R2 two sources", n, 1);
        go_idle();
        repeat (6) @(negedge clk);

        // R8: store does not overwrite a pending multiply
        produce(OP_MUL_L, 4'd5, 1'b1);
        produce(OP_ST, 4'd5, 1'b1);
        consume(OP_ALU, 4'd5, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        count_stall(n);
        chk("R8 store keeps entry", n, 3);
        go_idle();
        repeat (6) @(negedge clk);

        // R8: write bit clear keeps entry
        produce(OP_MUL_L, 4'd6, 1'b1);
        produce(OP_ALU, 4'd6, 1'b0);
        consume(OP_ALU, 4'd6, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        count_stall(n);
        chk("R8 no write keeps entry", n, 3);
        go_idle();
        repeat (6) @(negedge clk);

        // R9: newest producer replaces older one
        produce(OP_MUL_L, 4'd3, 1'b1);
        produce(OP_ALU, 4'd3, 1'b1);
        consume(OP_ALU, 4'd3, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        count_stall(n);
        chk("R9 overwrite", n, 1);
        go_idle();
        repeat (6) @(negedge clk);

        // R10: late consumer waits only the remaining cycles
        produce(OP_MUL_L, 4'd10, 1'b1);
        go_idle();
        @(negedge clk);
        consume(OP_ALU, 4'd10, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        count_stall(n);
        chk("R10 remaining wait", n, 2);
        go_idle();
        repeat (6) @(negedge clk);

        // R1: reset during a pending producer clears it
        produce(OP_MUL_L, 4'd4, 1'b1);
        @(negedge clk);
        iss_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        consume(OP_ALU, 4'd4, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
        count_stall(n);
        chk("R1 reset mid-run", n, 0);
        go_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule